// File: doc/BRIEF.md
# SDRAM Initialization and Refresh Scheduler

This block takes a single-data-rate SDRAM from reset to a usable state and then keeps its contents alive. Out of reset it holds the command bus, waits a power-up delay, closes every bank, issues a configurable number of auto-refresh commands, and writes the standard mode register followed by the extended mode register. The extended register holds the partial-array and drive-strength settings. Both register values are fixed parameters. Once the last load has settled, it raises a done flag. The access sequencer must refuse work until that flag is high.

After initialization an interval timer, derived from the clock frequency, marks one refresh every 31.25 µs. Over 64 ms this amounts to 2,048 refreshes. Each mark adds to a small owed-refresh count. While refreshes are owed the block raises a request. The access sequencer grants the bus once its current burst has finished. The block then drives a precharge-all, waits tRP, drives an auto-refresh, and holds the bus for tRFC before it hands the bus back. When the block does not own the bus, its command outputs sit at NOP so that a simple multiplexer can merge them.

Top module: `sdr_refresh_sched`

## Requirements
- R1: After reset the block owns the bus and drives NOP for INIT_WAIT cycles. In cycle INIT_WAIT it drives precharge-all, which is the precharge command with the top address bit (AP, bit ADDR_W-1) set to 1.
- R2: The first of INIT_REFS auto-refresh commands follows the precharge-all by T_RP cycles. Each later one follows the previous refresh by T_RFC cycles.
- R3: T_RFC cycles after the last initialization refresh, the block loads the mode register with bank bits 0 and address MODE_VAL. T_MRD cycles later it loads the extended register with the top bank bit 1 and address EXT_VAL.
- R4: init_done_o is low until T_MRD cycles after the extended register load. It rises in that cycle and never falls again before reset.
- R5: The refresh interval is REFI = CLK_MHZ*3125/100 cycles. Interval k ends in cycle done+k*REFI-1, where done is the cycle in which init_done_o rose. The request rises two cycles after that.
- R6: While ref_req_o is high and no grant has arrived, bus_own_o is low and the command is NOP. Whenever bus_own_o is low, the command is NOP.
- R7: gnt_i is sampled in a cycle with ref_req_o high. In the next cycle the block owns the bus and drives precharge-all. It drives auto-refresh T_RP cycles later and releases bus_own_o T_RFC cycles after the refresh.
- R8: Interval ends that are not yet served accumulate, up to MAX_DEBT. Once granted, the owed refreshes are served one after another, with each release followed by a new request in the next cycle.
- R9: cmd_o is {cs_n, ras_n, cas_n, we_n}. NOP is 0111, precharge is 0010, auto-refresh is 0001, and mode load is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gnt_i | input | 1 | Bus grant from the access sequencer |
| init_done_o | output | 1 | Initialization finished |
| ref_req_o | output | 1 | Refresh owed, bus wanted |
| bus_own_o | output | 1 | Scheduler drives the command bus |
| cmd_o | output | 4 | Command pins {cs_n, ras_n, cas_n, we_n} |
| ba_o | output | BANK_W | Bank select |
| addr_o | output | ADDR_W | Address pins |

## Verification
The bench builds the block with CLK_MHZ=4, which gives a 125-cycle refresh interval, so seven intervals fit in a short run. It uses INIT_WAIT=10, T_RP=3, T_RFC=5 and T_MRD=2; because these values all differ, an exchanged or mis-counted wait moves a command to a wrong cycle. With MAX_DEBT=3, four interval ends pass while the grant is withheld, so the debt reaches saturation and the back-to-back service of three refreshes can be observed.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

    // Command pins {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        ST_WAIT,
        ST_IPRE,
        ST_IREF,
        ST_LMR,
        ST_EMR,
        ST_IDLE,
        ST_REQ,
        ST_PRE,
        ST_REF
    } sched_st_e;

    typedef struct packed {
        sdr_cmd_e cmd;
        logic     ap;
        logic     bank_hi;
        logic     std_mode;
        logic     ext_mode;
    } cmd_slot_t;

    function automatic int unsigned refi_cycles(input int unsigned mhz);
        return (mhz * 3125) / 100;
    endfunction

    function automatic int unsigned max4(input int unsigned a, b, c, d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic cmd_slot_t slot_of(input sched_st_e st);
        cmd_slot_t s;
        s = '{cmd: CMD_NOP, ap: 1'b0, bank_hi: 1'b0, std_mode: 1'b0, ext_mode: 1'b0};
        case (st)
            ST_IPRE, ST_PRE: begin s.cmd = CMD_PRE; s.ap = 1'b1; end
            ST_IREF, ST_REF: s.cmd = CMD_REF;
            ST_LMR:          begin s.cmd = CMD_MRS; s.std_mode = 1'b1; end
            ST_EMR:          begin s.cmd = CMD_MRS; s.ext_mode = 1'b1; s.bank_hi = 1'b1; end
            default:         ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sdr_refi_timer.sv
module sdr_refi_timer #(
    parameter int unsigned REFI     = 3125,
    parameter int unsigned MAX_DEBT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic take_i,
    output logic owed_o
);
    localparam int CW = (REFI > 2) ? $clog2(REFI) : 1;
    localparam int DW = $clog2(MAX_DEBT + 1);

    logic [CW-1:0] cnt_q;
    logic [DW-1:0] debt_q;
    logic          tick;

    assign tick = run_i && (cnt_q == CW'(REFI - 1));

    always_ff @(posedge clk) begin
        if (rst || !run_i || tick) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            debt_q <= '0;
        end else begin
            case ({tick, take_i})
                2'b10: if (debt_q != DW'(MAX_DEBT)) debt_q <= debt_q + 1'b1;
                2'b01: if (debt_q != '0)            debt_q <= debt_q - 1'b1;
                default: ;
            endcase
        end
    end

    assign owed_o = (debt_q != '0);
endmodule

// File: rtl/sdr_sched_fsm.sv
module sdr_sched_fsm
    import sdr_init_pkg::*;
#(
    parameter int unsigned INIT_WAIT = 20000,
    parameter int unsigned T_RP      = 2,
    parameter int unsigned T_RFC     = 7,
    parameter int unsigned T_MRD     = 2,
    parameter int unsigned INIT_REFS = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      gnt_i,
    input  logic      owed_i,
    output sched_st_e st_o,
    output logic      done_o
);
    localparam int unsigned WMAX = max4(INIT_WAIT, T_RP, T_RFC, T_MRD);
    localparam int WW = $clog2(WMAX + 1);
    localparam int RW = $clog2(INIT_REFS + 1);

    sched_st_e     st_q, ret_q;
    logic [WW-1:0] wcnt_q;
    logic [RW-1:0] refs_q;
    logic          done_q;

    // Command at cycle k, wait state entered with N-2, next command at k+N.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_WAIT;
            ret_q  <= ST_IPRE;
            wcnt_q <= WW'(INIT_WAIT - 1);
            refs_q <= RW'(INIT_REFS);
            done_q <= 1'b0;
        end else begin
            case (st_q)
                ST_WAIT: begin
                    if (wcnt_q == '0) begin
                        st_q <= ret_q;
                        if (ret_q == ST_IDLE) done_q <= 1'b1;
                    end else begin
                        wcnt_q <= wcnt_q - 1'b1;
                    end
                end
                ST_IPRE: begin
                    st_q <= ST_WAIT; ret_q <= ST_IREF; wcnt_q <= WW'(T_RP - 2);
                end
                ST_IREF: begin
                    refs_q <= refs_q - 1'b1;
                    st_q   <= ST_WAIT;
                    ret_q  <= (refs_q == RW'(1)) ? ST_LMR : ST_IREF;
                    wcnt_q <= WW'(T_RFC - 2);
                end
                ST_LMR: begin
                    st_q <= ST_WAIT; ret_q <= ST_EMR; wcnt_q <= WW'(T_MRD - 2);
                end
                ST_EMR: begin
                    st_q <= ST_WAIT; ret_q <= ST_IDLE; wcnt_q <= WW'(T_MRD - 2);
                end
                ST_IDLE: if (owed_i) st_q <= ST_REQ;
                ST_REQ:  if (gnt_i)  st_q <= ST_PRE;
                ST_PRE: begin
                    st_q <= ST_WAIT; ret_q <= ST_REF; wcnt_q <= WW'(T_RP - 2);
                end
                ST_REF: begin
                    st_q <= ST_WAIT; ret_q <= ST_IDLE; wcnt_q <= WW'(T_RFC - 2);
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign st_o   = st_q;
    assign done_o = done_q;
endmodule

// File: rtl/sdr_cmd_drive.sv
module sdr_cmd_drive
    import sdr_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned BANK_W = 1,
    parameter logic [ADDR_W-1:0] MODE_VAL = '0,
    parameter logic [ADDR_W-1:0] EXT_VAL  = '0
) (
    input  sched_st_e         st_i,
    output sdr_cmd_e          cmd_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int AP = ADDR_W - 1;

    cmd_slot_t slot;

    always_comb begin
        slot   = slot_of(st_i);
        cmd_o  = slot.cmd;
        ba_o   = '0;
        addr_o = '0;
        ba_o[BANK_W-1] = slot.bank_hi;
        if (slot.std_mode)      addr_o = MODE_VAL;
        else if (slot.ext_mode) addr_o = EXT_VAL;
        addr_o[AP] = addr_o[AP] | slot.ap;
    end
endmodule

// File: rtl/sdr_refresh_sched.sv
module sdr_refresh_sched
    import sdr_init_pkg::*;
#(
    parameter int unsigned CLK_MHZ   = 100,
    parameter int unsigned INIT_WAIT = 20000,
    parameter int unsigned T_RP      = 2,
    parameter int unsigned T_RFC     = 7,
    parameter int unsigned T_MRD     = 2,
    parameter int unsigned INIT_REFS = 2,
    parameter int unsigned MAX_DEBT  = 4,
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned BANK_W    = 1,
    parameter logic [ADDR_W-1:0] MODE_VAL = 11'h037,
    parameter logic [ADDR_W-1:0] EXT_VAL  = 11'h000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gnt_i,
    output logic              init_done_o,
    output logic              ref_req_o,
    output logic              bus_own_o,
    output logic [3:0]        cmd_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int unsigned REFI = refi_cycles(CLK_MHZ);

    sched_st_e st;
    sdr_cmd_e  cmd_w;
    logic      done, owed;

    sdr_refi_timer #(.REFI(REFI), .MAX_DEBT(MAX_DEBT)) u_refi (
        .clk(clk), .rst(rst), .run_i(done),
        .take_i(st == ST_REF), .owed_o(owed)
    );

    sdr_sched_fsm #(
        .INIT_WAIT(INIT_WAIT), .T_RP(T_RP), .T_RFC(T_RFC),
        .T_MRD(T_MRD), .INIT_REFS(INIT_REFS)
    ) u_fsm (
        .clk(clk), .rst(rst), .gnt_i(gnt_i), .owed_i(owed),
        .st_o(st), .done_o(done)
    );

    sdr_cmd_drive #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .MODE_VAL(MODE_VAL), .EXT_VAL(EXT_VAL)
    ) u_drv (
        .st_i(st), .cmd_o(cmd_w), .ba_o(ba_o), .addr_o(addr_o)
    );

    assign cmd_o       = cmd_w;
    assign init_done_o = done;
    assign ref_req_o   = (st == ST_REQ);
    assign bus_own_o   = (st != ST_REQ) && (st != ST_IDLE);
endmodule

// File: rtl/sdr_sched_chk.sv
module sdr_sched_chk
    import sdr_init_pkg::*;
#(
    parameter int unsigned T_RP   = 2,
    parameter int unsigned T_RFC  = 7,
    parameter int unsigned T_MRD  = 2,
    parameter int unsigned ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              gnt_i,
    input logic              done_i,
    input logic              req_i,
    input logic              own_i,
    input logic [3:0]        cmd_i,
    input logic [ADDR_W-1:0] addr_i
);
    logic [7:0] s_pre, s_ref, s_mrs;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_pre <= 8'hFF; s_ref <= 8'hFF; s_mrs <= 8'hFF;
        end else begin
            if (cmd_i == CMD_PRE) s_pre <= 8'd1; else if (s_pre != 8'hFF) s_pre <= s_pre + 1'b1;
            if (cmd_i == CMD_REF) s_ref <= 8'd1; else if (s_ref != 8'hFF) s_ref <= s_ref + 1'b1;
            if (cmd_i == CMD_MRS) s_mrs <= 8'd1; else if (s_mrs != 8'hFF) s_mrs <= s_mrs + 1'b1;
        end
    end

    p_nop_unowned_r6: assert property (@(posedge clk) disable iff (rst)
        !own_i |-> cmd_i == CMD_NOP);
    p_req_not_owned_r6: assert property (@(posedge clk) disable iff (rst)
        req_i |-> !own_i);
    p_done_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        done_i |=> done_i);
    p_pre_all_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_i == CMD_PRE |-> addr_i[ADDR_W-1]);
    p_ref_after_pre_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_i == CMD_REF |-> s_pre >= 8'(T_RP));
    p_rfc_gap_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_i != CMD_NOP |-> s_ref >= 8'(T_RFC));
    p_mrd_gap_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_i != CMD_NOP |-> s_mrs >= 8'(T_MRD));
    p_grant_pre_r7: assert property (@(posedge clk) disable iff (rst)
        (req_i && gnt_i) |=> cmd_i == CMD_PRE);
endmodule

bind sdr_refresh_sched sdr_sched_chk #(
    .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .gnt_i(gnt_i), .done_i(init_done_o),
    .req_i(ref_req_o), .own_i(bus_own_o), .cmd_i(cmd_o), .addr_i(addr_o)
);

// File: tb/tb_sdr_refresh_sched.sv
module tb_sdr_refresh_sched;
    localparam int CLK_MHZ = 4, W = 10, RP = 3, RFC = 5, MRD = 2, NREF = 2, MAXD = 3;
    localparam int REFI = CLK_MHZ * 3125 / 100;
    localparam logic [10:0] MODEV = 11'h033, EXTV = 11'h020, APV = 11'h400;
    localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;
    localparam int D = W + RP + NREF * RFC + 2 * MRD;
    localparam int GNT_CYC = 800;

    logic clk = 1'b0, rst = 1'b1, gnt = 1'b1;
    logic done, req, own;
    logic [3:0] cmd;
    logic [0:0] ba;
    logic [10:0] addr;
    int cyc = 0, nchk = 0, nfail = 0;

    typedef struct { int c; logic [3:0] cmd; logic ba; logic [10:0] a; bit ca; string tag; } exp_t;
    exp_t expq[$];

    always #2 clk = ~clk;

    sdr_refresh_sched #(
        .CLK_MHZ(CLK_MHZ), .INIT_WAIT(W), .T_RP(RP), .T_RFC(RFC), .T_MRD(MRD),
        .INIT_REFS(NREF), .MAX_DEBT(MAXD), .ADDR_W(11), .BANK_W(1),
        .MODE_VAL(MODEV), .EXT_VAL(EXTV)
    ) dut (
        .clk(clk), .rst(rst), .gnt_i(gnt), .init_done_o(done), .ref_req_o(req),
        .bus_own_o(own), .cmd_o(cmd), .ba_o(ba), .addr_o(addr)
    );

    always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

    task automatic check(bit ok, string tag, string what, int act, int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, expv);
        end
    endtask

    task automatic push(int c, logic [3:0] k, logic b, logic [10:0] a, bit ca, string tag);
        exp_t e;
        e = '{c: c, cmd: k, ba: b, a: a, ca: ca, tag: tag};
        expq.push_back(e);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    // Monitor: every non-NOP command is compared with the queue head.
    always @(negedge clk) begin
        if (!rst && cmd != NOP) begin
            if (expq.size() == 0) begin
                check(1'b0, "R6", "unexpected command", int'(cmd), int'(NOP));
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(cyc == e.c, e.tag, "command cycle", cyc, e.c);
                check(cmd == e.cmd, "R9", "command code", int'(cmd), int'(e.cmd));
                check(ba[0] == e.ba, e.tag, "bank", int'(ba), int'(e.ba));
                if (e.ca) check(addr == e.a, e.tag, "address", int'(addr), int'(e.a));
            end
        end
    end

    task automatic at(int n);
        while (cyc < n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired: actual timeout expected finish");
        report();
    end

    initial begin
        // Initialization sequence (R1, R2, R3)
        push(W, PRE, 1'b0, APV, 1'b1, "R1");
        for (int i = 0; i < NREF; i++) push(W + RP + i * RFC, REF, 1'b0, '0, 1'b0, "R2");
        push(W + RP + NREF * RFC, MRS, 1'b0, MODEV, 1'b1, "R3");
        push(W + RP + NREF * RFC + MRD, MRS, 1'b1, EXTV, 1'b1, "R3");
        // Granted refreshes (R5, R7)
        for (int k = 1; k <= 2; k++) begin
            push(D + k * REFI + 2, PRE, 1'b0, APV, 1'b1, "R7");
            push(D + k * REFI + 2 + RP, REF, 1'b0, '0, 1'b0, "R5");
        end
        // Owed refreshes served back to back (R8)
        for (int j = 0; j < MAXD; j++) begin
            push(GNT_CYC + 1 + j * (RP + RFC + 2), PRE, 1'b0, APV, 1'b1, "R8");
            push(GNT_CYC + 1 + j * (RP + RFC + 2) + RP, REF, 1'b0, '0, 1'b0, "R8");
        end
        push(D + 7 * REFI + 2, PRE, 1'b0, APV, 1'b1, "R5");
        push(D + 7 * REFI + 2 + RP, REF, 1'b0, '0, 1'b0, "R5");

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        check(done == 1'b0, "R4", "done after reset", int'(done), 0);
        check(own == 1'b1, "R1", "bus owned in power-up wait", int'(own), 1);
        at(D - 1);
        check(done == 1'b0, "R4", "done before last delay", int'(done), 0);
        at(D);
        check(done == 1'b1, "R4", "done rises", int'(done), 1);
        check(own == 1'b0, "R6", "bus released at done", int'(own), 0);
        at(D + REFI);
        check(req == 1'b0, "R5", "no request before interval", int'(req), 0);
        at(D + REFI + 1);
        check(req == 1'b1, "R5", "request at interval", int'(req), 1);
        at(D + REFI + 2);
        check(own == 1'b1 && req == 1'b0, "R7", "owned after grant", int'({own, req}), 2);
        at(D + REFI + 2 + RP + RFC - 1);
        check(own == 1'b1, "R7", "held through tRFC", int'(own), 1);
        at(D + REFI + 2 + RP + RFC);
        check(own == 1'b0, "R7", "released after tRFC", int'(own), 0);
        at(290);
        gnt = 1'b0;
        at(D + 3 * REFI + 1);
        check(req == 1'b1, "R6", "request while grant withheld", int'(req), 1);
        at(700);
        check(req == 1'b1 && own == 1'b0, "R6", "waiting without bus", int'({req, own}), 2);
        check(done == 1'b1, "R4", "done stays high", int'(done), 1);
        at(GNT_CYC);
        gnt = 1'b1;
        at(GNT_CYC + 1 + MAXD * (RP + RFC + 2));
        check(own == 1'b0 && req == 1'b0, "R8", "idle after debt cleared", int'({own, req}), 0);
        at(960);
        check(expq.size() == 0, "R8", "expected commands left", expq.size(), 0);
        report();
    end
endmodule